// File: doc/BRIEF.md
# UART modem control and status unit

This block holds the modem control byte and the modem status byte of a 16550-style serial port. The control byte sets the two active-low handshake outputs (terminal ready and request to send). It also carries two spare bits and a loopback enable. The status byte reports the four active-low handshake inputs: clear to send, data set ready, ring and carrier detect. Each input is first passed through a synchroniser chain, then watched for changes.

A detected change is held in a sticky delta bit, and the unit raises a status event while any delta bit is set. Reading the status byte clears the delta bits. In loopback mode the external inputs are ignored, the four status inputs are taken from control bits instead, and both handshake outputs are parked at their inactive level. This lets software test the whole change-detection path without touching the line.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset, `dtr_n` and `rts_n` are 1, `ctl_rdata` is 0, `sts_rdata` is 0x00 and `msr_event` is 0, provided all input pins are held at 1.
- R2: A write (`ctl_we`) stores `ctl_wdata` in the control byte, which is visible on `ctl_rdata` after the clock edge. Bit 0 is terminal ready, bit 1 is request to send, bits 2 and 3 are spare outputs A and B, and bit 4 is loopback. Outside loopback, `dtr_n` = NOT bit 0 and `rts_n` = NOT bit 1.
- R3: Status bits 4, 5, 6 and 7 read the complement of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`. A pin change appears on `sts_rdata` after SYNC_STAGES+1 rising edges, and not before.
- R4: Status bits 0, 1 and 3 (clear-to-send, data-set-ready and carrier delta) are set when the matching input changes in either direction.
- R5: Status bit 2 (ring trailing edge) is set only when `ri_n` goes from 0 to 1. A 1-to-0 change of `ri_n` leaves it clear.
- R6: `sts_rdata` presents the status byte combinationally. A clock edge with `sts_re` high clears all four delta bits.
- R7: A change whose delta would be set on the same edge as a read leaves that delta bit set after the read.
- R8: `msr_event` is high exactly while at least one delta bit is set.
- R9: With loopback set, the status inputs come from the control byte: request to send drives clear to send, terminal ready drives data set ready, spare A drives ring and spare B drives carrier. Deltas follow these internal levels one edge after the control write. The external input pins have no effect, and `dtr_n` and `rts_n` stay at 1.
- R10: Entering or leaving loopback switches the level source, and any level that differs as a result sets its delta bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 5 | Control byte write data |
| ctl_rdata | output | 5 | Current control byte |
| sts_re | input | 1 | Status read strobe; clears deltas on the edge |
| sts_rdata | output | 8 | Status byte: deltas in 3:0, levels in 7:4 |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| msr_event | output | 1 | High while any delta bit is set |

## Verification
The bench builds the unit with SYNC_STAGES = 3 instead of the default 2. The pin-to-status latency then becomes four edges, and the checks sample one edge early and on time, so a chain that is the wrong length shows up as an early or late result. With the extra stage, the bench can also land a pin change exactly on the edge of a status read. It does this to check that the delta bit survives the read.

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [4:0] ctl_wdata,
  output logic [4:0] ctl_rdata,
  input  logic       sts_re,
  output logic [7:0] sts_rdata,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       msr_event
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [4:0] ctl_q;
  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] lvl, lvl_q, chg, dlt;
  logic       loop;

  assign loop = ctl_q[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 4'hF;
    end else begin
      sync_q[0] <= {dcd_n, ri_n, dsr_n, cts_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  // level order: 0 cts, 1 dsr, 2 ri, 3 dcd (active high)
  assign lvl = loop ? {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]} : ~sync_q[LAST];

  assign chg = {lvl[3] ^ lvl_q[3], lvl_q[2] & ~lvl[2], lvl[1] ^ lvl_q[1], lvl[0] ^ lvl_q[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q <= '0;
      dlt   <= '0;
    end else begin
      lvl_q <= lvl;
      dlt   <= (sts_re ? 4'h0 : dlt) | chg;
    end

  assign ctl_rdata = ctl_q;
  assign sts_rdata = {lvl_q, dlt};
  assign msr_event = |dlt;
  assign dtr_n     = ~(ctl_q[0] & ~loop);
  assign rts_n     = ~(ctl_q[1] & ~loop);

  initial assert (SYNC_STAGES >= 2);

  p_delta_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != 4'h0) |=> ((dlt & $past(chg)) == $past(chg)));

  p_teri_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt[2]) |-> $fell(lvl_q[2]));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_re && chg == 4'h0) |=> (dlt == 4'h0));

  p_event_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_event) |-> $past(chg != 4'h0));

  p_loop_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loop |-> (dtr_n && rts_n));

endmodule

// File: tb/test_modem_ctl_stat.sv
module test_modem_ctl_stat;
  localparam int SYNC = 3;
  localparam int LAT  = SYNC + 1;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, sts_re = 0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] ctl_rdata;
  logic [7:0] sts_rdata;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic dtr_n, rts_n, msr_event;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  modem_ctl_stat #(.SYNC_STAGES(SYNC)) i_modem_ctl_stat (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sts_re(sts_re), .sts_rdata(sts_rdata),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .msr_event(msr_event));

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    ctl_we = 1; ctl_wdata = v; tick(1); ctl_we = 0;
  endtask

  task automatic rd_sts(output logic [7:0] v);
    sts_re = 1; v = sts_rdata; tick(1); sts_re = 0;
  endtask

  task automatic t_reset;
    chk(sts_rdata, 8'h00, "R1 status");
    chk({dtr_n, rts_n}, 2'b11, "R1 pins");
    chk(ctl_rdata, 0, "R1 ctl");
    chk(msr_event, 0, "R1 event");
  endtask

  task automatic t_ctl;
    wr_ctl(5'h01);
    chk(ctl_rdata, 5'h01, "R2 readback");
    chk({dtr_n, rts_n}, 2'b01, "R2 dtr only");
    wr_ctl(5'h03);
    chk({dtr_n, rts_n}, 2'b00, "R2 both");
    wr_ctl(5'h00);
    chk({dtr_n, rts_n}, 2'b11, "R2 off");
  endtask

  task automatic t_levels;
    logic [7:0] v;
    cts_n = 0; tick(LAT - 1);
    chk(sts_rdata, 8'h00, "R3 not early");
    tick(1);
    chk(sts_rdata, 8'h11, "R3 cts level R4 delta");
    chk(msr_event, 1, "R8 event set");
    rd_sts(v);
    chk(v, 8'h11, "R6 read value");
    chk(sts_rdata, 8'h10, "R6 cleared");
    chk(msr_event, 0, "R8 event clear");
    dsr_n = 0; tick(LAT);
    rd_sts(v);
    chk(v, 8'h32, "R4 dsr fall");
    cts_n = 1; dsr_n = 1; tick(LAT);
    rd_sts(v);
    chk(v, 8'h03, "R4 cts dsr rise");
    dcd_n = 0; tick(LAT);
    rd_sts(v);
    chk(v, 8'h88, "R4 dcd fall");
    dcd_n = 1; tick(LAT);
    rd_sts(v);
    chk(v, 8'h08, "R4 dcd rise");
  endtask

  task automatic t_ring;
    logic [7:0] v;
    ri_n = 0; tick(LAT);
    chk(sts_rdata, 8'h40, "R5 ring start no delta");
    chk(msr_event, 0, "R5 R8 no event");
    ri_n = 1; tick(LAT);
    chk(sts_rdata, 8'h04, "R5 trailing edge");
    chk(msr_event, 1, "R8 ring event");
    rd_sts(v);
    chk(sts_rdata, 8'h00, "R6 ring cleared");
  endtask

  task automatic t_collide;
    logic [7:0] v;
    cts_n = 0; tick(LAT - 1);
    rd_sts(v);
    chk(v, 8'h00, "R7 read before change");
    chk(sts_rdata, 8'h11, "R7 delta kept");
    rd_sts(v);
    chk(sts_rdata, 8'h10, "R7 later read clears");
    cts_n = 1; tick(LAT);
    rd_sts(v);
    chk(v, 8'h01, "R7 restore");
  endtask

  task automatic t_loop;
    logic [7:0] v;
    wr_ctl(5'h10); tick(1);
    chk(sts_rdata, 8'h00, "R9 loop idle");
    chk({dtr_n, rts_n}, 2'b11, "R9 parked idle");
    wr_ctl(5'h1F);
    chk({dtr_n, rts_n}, 2'b11, "R9 parked active");
    tick(1);
    chk(sts_rdata, 8'hFB, "R9 loop levels and deltas");
    rd_sts(v);
    cts_n = 0; dsr_n = 0; ri_n = 0; dcd_n = 0; tick(LAT + 1);
    chk(sts_rdata, 8'hF0, "R9 pins ignored");
    chk(msr_event, 0, "R9 no event from pins");
    wr_ctl(5'h12); tick(1);
    chk(sts_rdata, 8'h1E, "R9 loop deltas and ring edge");
    rd_sts(v);
    cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1; tick(LAT + 1);
    chk(sts_rdata, 8'h10, "R9 pins still ignored");
    wr_ctl(5'h03); tick(1);
    chk(sts_rdata, 8'h01, "R10 exit loop delta");
    chk({dtr_n, rts_n}, 2'b00, "R2 R10 pins restored");
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    t_reset();
    t_ctl();
    t_levels();
    t_ring();
    t_collide();
    t_loop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule